// File: doc/BRIEF.md
# Serial Gamepad Poller

This block reads a 16-button gamepad built around a parallel-load shift register that hangs off general-purpose pins. A frame timer divides the system clock down to the frame rate, which is 60 Hz by default. A separate divider makes the slow serial clock for the pad. On each frame tick the controller does not start at once. It first waits for the next rising phase boundary of the divided pad clock. It then drives a load pulse and clocks the 16 button bits out of the pad.

The bits are captured in a private shift register. They are inverted, because the pad drives a 0 for a pressed button. The finished word is then copied in one cycle into a holding register. A host reads that register at offset 0 of a small read port. A debug byte output shows one half of the word at a time, so the state can be put on eight indicator pins.

Top module: `pad_poller`

## Requirements
- R1: After reset, pad_latch_o is 0, pad_clk_o is 1, poll_done_o is 0 and the held button word reads as 16'h0000.
- R2: A poll starts for every frame tick that arrives while the block is idle. Frame ticks come every CLK_HZ/FRAME_HZ cycles.
- R3: A poll raises pad_latch_o only on a rising phase boundary of the divided pad clock. The latch then stays high for exactly 2*HALF_DIV cycles, which is one pad-clock period.
- R4: After the latch falls, pad_clk_o makes exactly 16 low-then-high pulses. Each low half lasts HALF_DIV cycles. Outside these pulses, including while the latch is high, pad_clk_o is high.
- R5: Bit i of the result is the inverse of the i-th bit presented on pad_data_i. Bit 0 is the bit presented after the latch, before any clock pulse, so a result bit of 1 means pressed.
- R6: The held word changes only in the cycle the finished 16-bit value is committed. A read during a poll returns the previous word, and the word keeps its value between polls.
- R7: When rd_en_i is 1 and rd_addr_i is 0, rd_data_o shows the held word one cycle later. In every other case rd_data_o is 0 one cycle later.
- R8: dbg_byte_o shows bits [15:8] of the held word when dbg_hi_i is 1, and bits [7:0] when it is 0.
- R9: poll_done_o is a one-cycle pulse. It is high in the same cycle the new word first appears in the held register.
- R10: A frame tick that arrives while a poll is in progress is ignored. If a poll lasts longer than one frame, polls occur on every second frame tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pad_data_i | input | 1 | Serial data from the pad, active-low |
| pad_latch_o | output | 1 | Parallel-load pulse to the pad |
| pad_clk_o | output | 1 | Serial shift clock to the pad, idle high |
| poll_done_o | output | 1 | One-cycle strobe when a new word is committed |
| rd_en_i | input | 1 | Host read enable |
| rd_addr_i | input | ADDR_W | Host read offset; the word is at offset 0 |
| rd_data_o | output | NBITS | Registered read data |
| dbg_hi_i | input | 1 | Debug half select: 1 for the upper byte, 0 for the lower byte |
| dbg_byte_o | output | NBITS/2 | Selected half of the held word |

## Verification
A behavioural pad model is loaded with ~pattern on the latch and shifts on each clock rise. It is driven with all-released, all-pressed, single-bit patterns at each end of the word, and mixed asymmetric words. The end bits show whether the bit order is reversed or off by one. The all-0 and all-1 words show whether the inversion is missing, and the asymmetric words show whether bits are swapped or the byte halves of the debug output are mixed up. The frame period is set shorter than one poll, so the spacing between done strobes shows whether busy-time ticks are ignored. A read taken in the middle of a shift shows whether a partial word ever becomes visible.

// File: rtl/pad_pkg.sv
package pad_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_LATCH,
    ST_SHIFT,
    ST_DONE
  } poll_st_e;
endpackage

// File: rtl/pad_frame_timer.sv
module pad_frame_timer #(
  parameter int FRAME_DIV = 833333
) (
  input  logic clk,
  input  logic rst_n,
  output logic frame_tk
);
  localparam int FW = (FRAME_DIV > 2) ? $clog2(FRAME_DIV) : 1;

  logic [FW-1:0] cnt_q, cnt_n;

  assign frame_tk = (cnt_q == FW'(FRAME_DIV - 1));

  always_comb begin
    cnt_n = frame_tk ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/pad_clk_div.sv
module pad_clk_div #(
  parameter int HALF_DIV = 250
) (
  input  logic clk,
  input  logic rst_n,
  output logic half_tk,
  output logic rise_tk
);
  localparam int HW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;

  logic [HW-1:0] cnt_q, cnt_n;
  logic          ph_q, ph_n;

  assign half_tk = (cnt_q == HW'(HALF_DIV - 1));
  assign rise_tk = half_tk & ~ph_q;

  always_comb begin
    cnt_n = half_tk ? '0 : cnt_q + 1'b1;
    ph_n  = half_tk ? ~ph_q : ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      ph_q  <= ph_n;
    end
  end
endmodule

// File: rtl/pad_poll_fsm.sv
module pad_poll_fsm
  import pad_pkg::*;
#(
  parameter int NBITS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tk,
  input  logic             half_tk,
  input  logic             rise_tk,
  input  logic             data_s,
  output logic             latch_o,
  output logic             pclk_o,
  output logic             done_o,
  output logic [NBITS-1:0] word_o
);
  localparam int BW = (NBITS > 2) ? $clog2(NBITS) : 1;

  poll_st_e         st_q, st_n;
  logic             hc_q, hc_n;
  logic [BW-1:0]    bidx_q, bidx_n;
  logic [NBITS-1:0] sh_q, sh_n;
  logic [NBITS-1:0] word_q, word_n;
  logic             latch_q, latch_n;
  logic             pclk_q, pclk_n;
  logic             done_q, done_n;

  always_comb begin
    st_n    = st_q;
    hc_n    = hc_q;
    bidx_n  = bidx_q;
    sh_n    = sh_q;
    word_n  = word_q;
    latch_n = latch_q;
    pclk_n  = pclk_q;
    done_n  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (frame_tk) st_n = ST_ALIGN;
      end
      ST_ALIGN: begin
        if (rise_tk) begin
          latch_n = 1'b1;
          hc_n    = 1'b0;
          st_n    = ST_LATCH;
        end
      end
      ST_LATCH: begin
        if (half_tk) begin
          if (!hc_q) begin
            hc_n = 1'b1;
          end else begin
            latch_n = 1'b0;
            pclk_n  = 1'b0;
            bidx_n  = '0;
            st_n    = ST_SHIFT;
          end
        end
      end
      ST_SHIFT: begin
        if (half_tk) begin
          if (!pclk_q) begin
            sh_n[bidx_q] = ~data_s;
            pclk_n       = 1'b1;
            if (bidx_q == BW'(NBITS - 1)) st_n = ST_DONE;
          end else begin
            pclk_n = 1'b0;
            bidx_n = bidx_q + 1'b1;
          end
        end
      end
      ST_DONE: begin
        word_n = sh_q;
        done_n = 1'b1;
        st_n   = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      hc_q    <= 1'b0;
      bidx_q  <= '0;
      sh_q    <= '0;
      word_q  <= '0;
      latch_q <= 1'b0;
      pclk_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      hc_q    <= hc_n;
      bidx_q  <= bidx_n;
      sh_q    <= sh_n;
      word_q  <= word_n;
      latch_q <= latch_n;
      pclk_q  <= pclk_n;
      done_q  <= done_n;
    end
  end

  assign latch_o = latch_q;
  assign pclk_o  = pclk_q;
  assign done_o  = done_q;
  assign word_o  = word_q;
endmodule

// File: rtl/pad_poller.sv
module pad_poller #(
  parameter int CLK_HZ   = 50_000_000,
  parameter int FRAME_HZ = 60,
  parameter int PAD_HZ   = 100_000,
  parameter int NBITS    = 16,
  parameter int ADDR_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pad_data_i,
  output logic               pad_latch_o,
  output logic               pad_clk_o,
  output logic               poll_done_o,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [NBITS-1:0]   rd_data_o,
  input  logic               dbg_hi_i,
  output logic [NBITS/2-1:0] dbg_byte_o
);
  localparam int FRAME_DIV = CLK_HZ / FRAME_HZ;
  localparam int HALF_DIV  = CLK_HZ / (2 * PAD_HZ);
  localparam int DBG_W     = NBITS / 2;

  logic [1:0]       rst_pipe;
  logic             rst_sn;
  logic             d_meta, d_sync;
  logic             frame_tk, half_tk, rise_tk;
  logic [NBITS-1:0] result_w;
  logic [NBITS-1:0] rd_q, rd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      d_meta <= 1'b1;
      d_sync <= 1'b1;
    end else begin
      d_meta <= pad_data_i;
      d_sync <= d_meta;
    end
  end

  pad_frame_timer #(.FRAME_DIV(FRAME_DIV)) u_frame (
    .clk      (clk),
    .rst_n    (rst_sn),
    .frame_tk (frame_tk)
  );

  pad_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk     (clk),
    .rst_n   (rst_sn),
    .half_tk (half_tk),
    .rise_tk (rise_tk)
  );

  pad_poll_fsm #(.NBITS(NBITS)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sn),
    .frame_tk (frame_tk),
    .half_tk  (half_tk),
    .rise_tk  (rise_tk),
    .data_s   (d_sync),
    .latch_o  (pad_latch_o),
    .pclk_o   (pad_clk_o),
    .done_o   (poll_done_o),
    .word_o   (result_w)
  );

  always_comb begin
    rd_n = (rd_en_i && (rd_addr_i == '0)) ? result_w : '0;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) rd_q <= '0;
    else         rd_q <= rd_n;
  end

  assign rd_data_o  = rd_q;
  assign dbg_byte_o = dbg_hi_i ? result_w[NBITS-1:DBG_W] : result_w[DBG_W-1:0];
endmodule

// File: rtl/pad_poller_chk.sv
module pad_poller_chk #(
  parameter int NBITS    = 16,
  parameter int ADDR_W   = 4,
  parameter int HALF_DIV = 250
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rise_tk,
  input logic              latch,
  input logic              pclk,
  input logic              done,
  input logic [NBITS-1:0]  result,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [NBITS-1:0]  rd_data
);
  localparam int LW = 2 * HALF_DIV;
  localparam int CW = $clog2(LW + 2);

  logic [CW-1:0] lcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lcnt <= '0;
    else if (latch) lcnt <= lcnt + 1'b1;
    else            lcnt <= '0;
  end

  p_latch_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch) |-> $past(rise_tk));

  p_latch_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    latch |-> (lcnt < CW'(LW)));

  p_clk_high_in_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    latch |-> pclk);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_word_atomic_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);

  p_read_other_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && (rd_addr == '0)) |=> (rd_data == '0));
endmodule

bind pad_poller pad_poller_chk #(
  .NBITS    (NBITS),
  .ADDR_W   (ADDR_W),
  .HALF_DIV (HALF_DIV)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sn),
  .rise_tk (rise_tk),
  .latch   (pad_latch_o),
  .pclk    (pad_clk_o),
  .done    (poll_done_o),
  .result  (result_w),
  .rd_en   (rd_en_i),
  .rd_addr (rd_addr_i),
  .rd_data (rd_data_o)
);

// File: tb/pad_poller_test.sv
module pad_poller_test;
  localparam int CLK_P = 10;
  localparam int NB    = 16;
  localparam int AW    = 4;
  localparam int FD    = 100;
  localparam int HD    = 4;
  localparam int NPOLL = 8;

  logic          clk;
  logic          rst_n;
  logic          pad_data;
  logic          pad_latch_o, pad_clk_o, poll_done_o;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [NB-1:0] rd_data;
  logic          dbg_hi;
  logic [7:0]    dbg_byte;

  pad_poller #(
    .CLK_HZ(24000), .FRAME_HZ(240), .PAD_HZ(3000), .NBITS(NB), .ADDR_W(AW)
  ) uut (
    .clk(clk), .rst_n(rst_n), .pad_data_i(pad_data),
    .pad_latch_o(pad_latch_o), .pad_clk_o(pad_clk_o), .poll_done_o(poll_done_o),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .dbg_hi_i(dbg_hi), .dbg_byte_o(dbg_byte)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  // pad model: active-low parallel-load shift register
  logic [NB-1:0] pattern;
  logic [NB-1:0] pad_sr;
  always @(posedge pad_latch_o or posedge pad_clk_o) begin
    if (pad_latch_o) pad_sr <= ~pattern;
    else             pad_sr <= {1'b1, pad_sr[NB-1:1]};
  end
  assign pad_data = pad_sr[0];

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;
  logic [NB-1:0] exp_q[$];

  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wrap_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic logic [NB-1:0] pat_of(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h0001;
      3: return 16'h8000;
      4: return 16'hA5C3;
      5: return 16'h5A3C;
      6: return 16'h1234;
      default: return 16'hF00D;
    endcase
  endfunction

  // driver: presents each pattern to the pad while idle and queues the expectation
  initial begin
    pattern = pat_of(0);
    exp_q.push_back(pat_of(0));
    @(posedge rst_n);
    for (int i = 1; i < NPOLL; i++) begin
      do @(negedge clk); while (!poll_done_o);
      pattern = pat_of(i);
      exp_q.push_back(pat_of(i));
    end
  end

  // pad-side waveform monitor: R3 latch width, R4 pulse count and low width
  initial begin
    int hi_run = 0;
    int lo_run = 0;
    int rises = 0;
    logic pl = 1'b0;
    logic pc = 1'b1;
    @(posedge rst_n);
    repeat (3) @(negedge clk);
    forever begin
      @(negedge clk);
      if (pad_latch_o) begin
        hi_run++;
        check(pad_clk_o === 1'b1, "R4 clock high during latch", {31'd0, pad_clk_o}, 32'd1);
      end else if (pl) begin
        check(hi_run == 2*HD, "R3 latch width", hi_run, 2*HD);
        hi_run = 0;
      end
      if (!pad_clk_o) lo_run++;
      else if (!pc) begin
        rises++;
        check(lo_run == HD, "R4 clock low half", lo_run, HD);
        lo_run = 0;
      end
      if (poll_done_o) begin
        check(rises == NB, "R4 pulse count", rises, NB);
        rises = 0;
      end
      pl = pad_latch_o;
      pc = pad_clk_o;
    end
  end

  // monitor / scoreboard
  initial begin
    int last_t = -1;
    logic [NB-1:0] exp;
    rd_en = 1'b0; rd_addr = '0; dbg_hi = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pad_latch_o === 1'b0, "R1 latch", {31'd0, pad_latch_o}, 0);
    check(pad_clk_o === 1'b1, "R1 pad clock", {31'd0, pad_clk_o}, 1);
    check(poll_done_o === 1'b0, "R1 done", {31'd0, poll_done_o}, 0);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(rd_data === 16'h0000, "R1 word", {16'd0, rd_data}, 0);

    for (int p = 0; p < NPOLL; p++) begin
      do @(negedge clk); while (!poll_done_o);
      if (last_t >= 0)
        check(cyc - last_t == 2*FD, "R2 R10 poll spacing", cyc - last_t, 2*FD);
      last_t = cyc;
      exp = exp_q.pop_front();
      // R8 debug halves
      dbg_hi = 1'b0; #1;
      check(dbg_byte === exp[7:0], "R8 low byte", {24'd0, dbg_byte}, {24'd0, exp[7:0]});
      dbg_hi = 1'b1; #1;
      check(dbg_byte === exp[15:8], "R8 high byte", {24'd0, dbg_byte}, {24'd0, exp[15:8]});
      // R5 / R7 read at offset 0
      rd_en = 1'b1; rd_addr = '0;
      @(negedge clk);
      check(rd_data === exp, "R5 R7 word read", {16'd0, rd_data}, {16'd0, exp});
      check(poll_done_o === 1'b0, "R9 done one cycle", {31'd0, poll_done_o}, 0);
      rd_en = 1'b0;
      @(negedge clk);
      check(rd_data === '0, "R7 no enable", {16'd0, rd_data}, 0);
      rd_en = 1'b1; rd_addr = 4'd3;
      @(negedge clk);
      check(rd_data === '0, "R7 other offset", {16'd0, rd_data}, 0);
      rd_en = 1'b0; rd_addr = '0;
      if (p < NPOLL - 1) begin
        // R6 read in the middle of the next shift returns the previous word
        @(posedge pad_latch_o);
        repeat (60) @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(rd_data === exp, "R6 mid-poll hold", {16'd0, rd_data}, {16'd0, exp});
      end
    end
    finished = 1;
    wrap_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    wrap_up();
  end
endmodule